// File: doc/BRIEF.md
# NAND Prefetch and Write-Posting Engine

This block moves byte streams between a CPU and a NAND chip select through a 64-byte FIFO. In prefetch mode it reads a programmed number of bytes from the device and queues them for the CPU. Each device read returns one byte on an 8-bit device, or two bytes on a 16-bit device, low byte first. The CPU then pops the FIFO one byte at a time. Each time the occupancy falls to a programmed level, the engine schedules a refill.

In posting mode the CPU pushes bytes, and the engine forwards them as device write cycles. On a 16-bit device it pairs two consecutive bytes into one word.

Software controls the engine through six word registers: configuration, transfer count, start/stop, a read-only status word, interrupt status and interrupt enable. The engine raises an interrupt when the FIFO pointer reaches the threshold and when the transfer completes. If DMA is enabled, it also raises a DMA request while prefetched data is waiting.

Top module: `nand_pf_engine`

## Requirements
- R1: After reset, the configuration register reads 0x00004000 and the transfer-count, control, status, interrupt-status and interrupt-enable registers read 0. The outputs irq_o, dma_req_o, dev_rd_o, dev_wr_o and route_en_o are low.
- R2: Register addresses are 0 config, 1 transfer count, 2 control, 3 status, 4 interrupt status and 5 interrupt enable.
  - A configuration write stores the data ANDed with 0x7F8F7FBF.
  - Config bit 0 selects posting (1) or prefetch (0), and bit 2 enables the DMA request.
  - Bit 7 drives route_en_o, bits 14:8 are the threshold and bits 26:24 drive route_cs_o.
- R3: While the engine runs (control reads 1), writes to the configuration and transfer-count registers have no effect. The transfer count holds 14 bits.
- R4: Writing 1 to control bit 0 while the engine is stopped loads the remaining count from the transfer count.
  - In prefetch mode the pointer clears, and a fill moves min(64 − pointer, remaining) bytes, one device read per cycle.
  - Each byte pushed into the FIFO increments the pointer and decrements the remaining count.
- R5: With dev_wide_i high, the fill size is rounded down to an even number. Each device read pushes dev_rdata_i[7:0] and then dev_rdata_i[15:8].
- R6: In prefetch mode, a pulse on fifo_rd_i returns the oldest byte and decrements the pointer.
  - When the pointer is already 0, a read leaves it at 0.
  - In posting mode a read returns 0 and changes nothing.
- R7: A CPU read that leaves the pointer equal to 64 − threshold drops dma_req_o and starts a refill. At the end of each fill, dma_req_o rises if DMA is enabled and the pointer is non-zero.
- R8: The status word carries the pointer in bits 31:24, (pointer ≥ threshold) in bit 16 and the remaining count in bits 13:0. All other bits are 0.
- R9: Interrupt status bit 0 is set while pointer ≥ threshold. Bit 1 is set when the remaining count reaches 0 while running, and the engine then stops by itself.
- R10: In 8-bit posting mode, each fifo_wr_i with a non-zero remaining count produces one dev_wr_o pulse on the next cycle, with data {8'h00, byte}, and decrements the remaining count. Starting posting sets the pointer to 64. FIFO writes in prefetch mode, or with a remaining count of 0, are ignored.
- R11: In 16-bit posting mode the first byte is held and the pointer drops to 63. The second byte issues one device write of {second, first}, restores the pointer to 64 and decrements the count once.
- R12: Writing 1s to the interrupt status register clears those bits. The enable register keeps only bits 0xF03. irq_o is high exactly when status AND enable is non-zero.
- R13: Writing 0 to control bit 0 while the engine runs stops it and zeroes the remaining count, without setting interrupt status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| fifo_rd_i | input | 1 | CPU byte read strobe |
| fifo_rdata_o | output | 8 | CPU byte read data |
| fifo_wr_i | input | 1 | CPU byte write strobe |
| fifo_wdata_i | input | 8 | CPU byte write data |
| dev_wide_i | input | 1 | Selected device is 16 bits wide |
| dev_rd_o | output | 1 | Device read cycle, data sampled this cycle |
| dev_rdata_i | input | 16 | Device read data |
| dev_wr_o | output | 1 | Device write cycle |
| dev_wdata_o | output | 16 | Device write data |
| route_en_o | output | 1 | Route the selected chip select to the engine |
| route_cs_o | output | 3 | Chip select served by the engine |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |

## Verification
The hardest situation to reach is a refill that starts while the CPU is still draining. The pointer must land exactly on 64 − threshold, and the remaining count must then be smaller than the free space, so that the last fill is partial and completion fires from that fill.

The stimulus uses a transfer of 100 bytes with a threshold of 16. It reads in batches of 16 with pauses between them, so each batch triggers a refill from a known pointer: the refills move 16, 16 and then 4 bytes. After that it drains the FIFO across the trigger point once more and checks the full byte order against the device's data pattern.

// File: rtl/nand_pf_pkg.sv
package nand_pf_pkg;
  localparam int unsigned PF_DEPTH = 64;
  localparam int unsigned PF_CNT_W = 14;

  typedef enum logic [2:0] {
    A_CFG  = 3'd0,
    A_TCNT = 3'd1,
    A_CTRL = 3'd2,
    A_STAT = 3'd3,
    A_ISR  = 3'd4,
    A_IER  = 3'd5
  } reg_addr_e;

  localparam logic [31:0] CFG_MASK  = 32'h7F8F_7FBF;
  localparam logic [31:0] CFG_RESET = 32'h0000_4000;
  localparam logic [15:0] IER_MASK  = 16'h0F03;
endpackage

// File: rtl/pf_fifo.sv
module pf_fifo #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        push_i,
  input  logic        push_wide_i,
  input  logic [15:0] push_data_i,
  input  logic        pop_i,
  output logic [7:0]  rd_data_o
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_idx_q, rd_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
    end else if (clear_i) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
    end else begin
      if (push_i) wr_idx_q <= wr_idx_q + (push_wide_i ? AW'(2) : AW'(1));
      if (pop_i)  rd_idx_q <= rd_idx_q + AW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !clear_i) begin
      mem[wr_idx_q] <= push_data_i[7:0];
      if (push_wide_i) mem[wr_idx_q + AW'(1)] <= push_data_i[15:8];
    end
  end

  assign rd_data_o = mem[rd_idx_q];
endmodule

// File: rtl/pf_irq.sv
module pf_irq
  import nand_pf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        set_thr_i,
  input  logic        set_done_i,
  input  logic        clr_we_i,
  input  logic        en_we_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] status_o,
  output logic [15:0] enable_o,
  output logic        irq_o
);
  logic [1:0]  st_q;
  logic [15:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      // set wins over a same-cycle clear
      st_q[0] <= set_thr_i  | (st_q[0] & ~(clr_we_i & wdata_i[0]));
      st_q[1] <= set_done_i | (st_q[1] & ~(clr_we_i & wdata_i[1]));
      if (en_we_i) en_q <= wdata_i & IER_MASK;
    end
  end

  assign status_o = {14'd0, st_q};
  assign enable_o = en_q;
  assign irq_o    = |(status_o & en_q);

  p_w1c_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && wdata_i[1] && !set_done_i) |=> !status_o[1]);
endmodule

// File: rtl/nand_pf_engine.sv
module nand_pf_engine
  import nand_pf_pkg::*;
#(
  parameter int unsigned DEPTH = PF_DEPTH,
  parameter int unsigned CNT_W = PF_CNT_W,
  localparam int unsigned PTR_W = $clog2(DEPTH) + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        fifo_rd_i,
  output logic [7:0]  fifo_rdata_o,
  input  logic        fifo_wr_i,
  input  logic [7:0]  fifo_wdata_i,
  input  logic        dev_wide_i,
  output logic        dev_rd_o,
  input  logic [15:0] dev_rdata_i,
  output logic        dev_wr_o,
  output logic [15:0] dev_wdata_o,
  output logic        route_en_o,
  output logic [2:0]  route_cs_o,
  output logic        irq_o,
  output logic        dma_req_o
);
  localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

  logic [31:0]       cfg_q;
  logic [CNT_W-1:0]  tcnt_q, remain_q, remain_n;
  logic              running_q, filling_q, fill_pend_q, dma_q, dev_wr_q;
  logic [PTR_W-1:0]  ptr_q, ptr_n, fill_left_q, step, room, calc_raw, calc;
  logic [7:0]        held_q, fifo_byte;
  logic [15:0]       dev_wdata_q, isr, ier;

  logic dir_post, dma_en, wide;
  logic [6:0] thr;
  reg_addr_e addr;
  logic cfg_we, tc_we, ctrl_we, isr_we, ier_we, start, stop, active;
  logic push, pop, trig, fill_last, finish;
  logic post_wr, post_dev, post_done, fill_done, done, thr_hit;

  assign addr     = reg_addr_e'(reg_addr_i);
  assign dir_post = cfg_q[0];
  assign dma_en   = cfg_q[2];
  assign thr      = cfg_q[14:8];
  assign wide     = dev_wide_i;

  assign cfg_we  = reg_we_i && addr == A_CFG  && !running_q;
  assign tc_we   = reg_we_i && addr == A_TCNT && !running_q;
  assign ctrl_we = reg_we_i && addr == A_CTRL;
  assign isr_we  = reg_we_i && addr == A_ISR;
  assign ier_we  = reg_we_i && addr == A_IER;
  assign start   = ctrl_we &&  reg_wdata_i[0] && !running_q;
  assign stop    = ctrl_we && !reg_wdata_i[0] &&  running_q;
  assign active  = !start && !stop;

  always_comb begin
    step     = wide ? PTR_W'(2) : PTR_W'(1);
    room     = FULL - ptr_q;
    calc_raw = (CNT_W'(room) > remain_q) ? remain_q[PTR_W-1:0] : room;
    calc     = wide ? {calc_raw[PTR_W-1:1], 1'b0} : calc_raw;
    push     = filling_q;
    pop      = fifo_rd_i && !dir_post && ptr_q != '0;
    trig     = pop && (ptr_q - PTR_W'(1) == FULL - PTR_W'(thr));
    fill_last = filling_q && fill_left_q == step;
    finish   = fill_last || (fill_pend_q && !filling_q && calc == '0);
    ptr_n    = ptr_q + (push ? step : '0) - (pop ? PTR_W'(1) : '0);
    remain_n = remain_q - (push ? CNT_W'(step) : '0);
    post_wr  = fifo_wr_i && dir_post && remain_q != '0;
    post_dev = post_wr && (!wide || ptr_q != FULL);
    post_done = post_dev && remain_q == CNT_W'(1);
    fill_done = finish && running_q && remain_n == '0;
    done     = active && (post_done || fill_done);
    thr_hit  = ptr_q >= PTR_W'(thr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q       <= CFG_RESET;
      tcnt_q      <= '0;
      remain_q    <= '0;
      running_q   <= 1'b0;
      filling_q   <= 1'b0;
      fill_pend_q <= 1'b0;
      fill_left_q <= '0;
      ptr_q       <= '0;
      dma_q       <= 1'b0;
      dev_wr_q    <= 1'b0;
      dev_wdata_q <= '0;
      held_q      <= '0;
    end else begin
      dev_wr_q <= 1'b0;
      if (cfg_we) cfg_q  <= reg_wdata_i & CFG_MASK;
      if (tc_we)  tcnt_q <= reg_wdata_i[CNT_W-1:0];
      if (start) begin
        running_q   <= 1'b1;
        remain_q    <= tcnt_q;
        filling_q   <= 1'b0;
        fill_left_q <= '0;
        dma_q       <= 1'b0;
        ptr_q       <= dir_post ? FULL : '0;
        fill_pend_q <= !dir_post;
      end else if (stop) begin
        running_q   <= 1'b0;
        remain_q    <= '0;
        filling_q   <= 1'b0;
        fill_pend_q <= 1'b0;
        fill_left_q <= '0;
      end else begin
        if (post_wr) begin
          if (!post_dev) begin
            held_q <= fifo_wdata_i;
            ptr_q  <= FULL - PTR_W'(1);
          end else begin
            dev_wr_q    <= 1'b1;
            dev_wdata_q <= wide ? {fifo_wdata_i, held_q} : {8'h00, fifo_wdata_i};
            remain_q    <= remain_q - CNT_W'(1);
            if (wide) ptr_q <= FULL;
          end
        end else begin
          ptr_q    <= ptr_n;
          remain_q <= remain_n;
        end
        if (filling_q) begin
          fill_left_q <= fill_left_q - step;
          if (fill_last) filling_q <= 1'b0;
        end else if (fill_pend_q) begin
          fill_pend_q <= 1'b0;
          if (calc != '0) begin
            filling_q   <= 1'b1;
            fill_left_q <= calc;
          end
        end
        if (finish) dma_q <= dma_en && ptr_n != '0;
        if (done)   running_q <= 1'b0;
        if (trig) begin
          fill_pend_q <= 1'b1;
          dma_q       <= 1'b0;
        end
      end
    end
  end

  pf_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start),
    .push_i      (push),
    .push_wide_i (wide),
    .push_data_i (dev_rdata_i),
    .pop_i       (pop),
    .rd_data_o   (fifo_byte)
  );

  pf_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_thr_i  (thr_hit),
    .set_done_i (done),
    .clr_we_i   (isr_we),
    .en_we_i    (ier_we),
    .wdata_i    (reg_wdata_i[15:0]),
    .status_o   (isr),
    .enable_o   (ier),
    .irq_o      (irq_o)
  );

  always_comb begin
    unique case (addr)
      A_CFG:   reg_rdata_o = cfg_q;
      A_TCNT:  reg_rdata_o = 32'(tcnt_q);
      A_CTRL:  reg_rdata_o = {31'd0, running_q};
      A_STAT:  reg_rdata_o = {8'(ptr_q), 7'd0, thr_hit, 16'(remain_q)};
      A_ISR:   reg_rdata_o = {16'd0, isr};
      A_IER:   reg_rdata_o = {16'd0, ier};
      default: reg_rdata_o = '0;
    endcase
  end

  assign fifo_rdata_o = dir_post ? 8'h00 : fifo_byte;
  assign dev_rd_o     = filling_q;
  assign dev_wr_o     = dev_wr_q;
  assign dev_wdata_o  = dev_wdata_q;
  assign dma_req_o    = dma_q;
  assign route_en_o   = cfg_q[7];
  assign route_cs_o   = cfg_q[26:24];

  p_ptr_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= FULL);
  p_cfg_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && reg_we_i && addr == A_CFG) |=> $stable(cfg_q));
  p_even_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filling_q && wide) |-> !fill_left_q[0]);
  p_stop_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (!running_q && remain_q == '0));
  p_start_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (running_q && remain_q == $past(tcnt_q)));
  p_empty_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_rd_i && ptr_q == '0 && !filling_q && active) |=> ptr_q == '0);
endmodule

// File: tb/nand_pf_engine_tb.sv
module nand_pf_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fifo_rd = 1'b0;
  logic [7:0]  fifo_rdata;
  logic        fifo_wr = 1'b0;
  logic [7:0]  fifo_wdata = '0;
  logic        dev_wide = 1'b0;
  logic        dev_rd;
  logic [15:0] dev_rdata;
  logic        dev_wr;
  logic [15:0] dev_wdata;
  logic        route_en;
  logic [2:0]  route_cs;
  logic        irq, dma_req;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int dev_idx = 0;
  logic [15:0] exp_q[$];

  always #2.5 clk = ~clk;

  nand_pf_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .fifo_rd_i(fifo_rd), .fifo_rdata_o(fifo_rdata), .fifo_wr_i(fifo_wr), .fifo_wdata_i(fifo_wdata),
    .dev_wide_i(dev_wide), .dev_rd_o(dev_rd), .dev_rdata_i(dev_rdata),
    .dev_wr_o(dev_wr), .dev_wdata_o(dev_wdata),
    .route_en_o(route_en), .route_cs_o(route_cs), .irq_o(irq), .dma_req_o(dma_req)
  );

  function automatic logic [7:0] pat(int n);
    return 8'(n * 7 + 3);
  endfunction

  // device model: one read per cycle of dev_rd
  assign dev_rdata = dev_wide ? {pat(2 * dev_idx + 1), pat(2 * dev_idx)} : {8'h00, pat(dev_idx)};
  always @(posedge clk) if (dev_rd) dev_idx <= dev_idx + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // scoreboard monitor for device writes
  always @(negedge clk) begin
    if (rst_n && dev_wr) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected device write", 32'(dev_wdata), 32'hFFFF_FFFF);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(dev_wdata == e, "R10/R11 device write data", 32'(dev_wdata), 32'(e));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    reg_addr = a;
    #1 chk(reg_rdata == e, req, reg_rdata, e);
  endtask

  task automatic fifo_pop(output logic [7:0] v);
    @(negedge clk);
    fifo_rd = 1'b1;
    #1 v = fifo_rdata;
    @(posedge clk); #1;
    fifo_rd = 1'b0;
  endtask

  task automatic fifo_push(input logic [7:0] d);
    @(negedge clk);
    fifo_wr = 1'b1; fifo_wdata = d;
    @(posedge clk); #1;
    fifo_wr = 1'b0;
  endtask

  task automatic pop_expect(input int first, input int n, input int base, input string req);
    for (int k = first; k < first + n; k++) begin
      logic [7:0] v;
      fifo_pop(v);
      chk(v == pat(base + k), req, 32'(v), 32'(pat(base + k)));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int base;
    logic [7:0] v;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    rd_chk(3'd0, 32'h0000_4000, "R1 config reset");
    rd_chk(3'd1, 0, "R1 tcnt reset");
    rd_chk(3'd2, 0, "R1 ctrl reset");
    rd_chk(3'd3, 0, "R1 status reset");
    rd_chk(3'd4, 0, "R1 isr reset");
    rd_chk(3'd5, 0, "R1 ier reset");
    chk({irq, dma_req, dev_rd, dev_wr, route_en} == 5'b0, "R1 outputs low",
        32'({irq, dma_req, dev_rd, dev_wr, route_en}), 0);

    // R2 config mask and field outputs
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk(3'd0, 32'h7F8F_7FBF, "R2 config mask");
    chk(route_en && route_cs == 3'd7, "R2 route fields", {28'd0, route_en, route_cs}, 32'hF);

    // prefetch, 8-bit, threshold 16, dma on, cs 3
    wr(3'd0, 32'h0300_1084);
    chk(route_cs == 3'd3, "R2 route cs", 32'(route_cs), 3);
    wr(3'd1, 32'hFFFF_C064);
    rd_chk(3'd1, 32'h0000_0064, "R3 tcnt 14 bits");
    wr(3'd1, 100);
    base = dev_idx;
    wr(3'd2, 1);
    cyc(80);
    rd_chk(3'd3, 32'h4001_0024, "R4 R8 first fill status");
    rd_chk(3'd2, 1, "R4 running");
    chk(dma_req == 1'b1, "R7 dma after fill", 32'(dma_req), 1);
    wr(3'd0, 0);
    rd_chk(3'd0, 32'h0300_1084, "R3 config frozen");
    wr(3'd1, 5);
    rd_chk(3'd1, 100, "R3 tcnt frozen");
    fifo_push(8'h55); // R10 ignored in prefetch mode
    pop_expect(0, 16, base, "R6 prefetch order");
    @(negedge clk); #1;
    chk(dma_req == 1'b0, "R7 dma drops at trigger", 32'(dma_req), 0);
    cyc(30);
    rd_chk(3'd3, 32'h4001_0014, "R7 refill 16");
    chk(dma_req == 1'b1, "R7 dma back", 32'(dma_req), 1);
    pop_expect(16, 16, base, "R6 prefetch order");
    cyc(30);
    rd_chk(3'd3, 32'h4001_0004, "R7 second refill");
    pop_expect(32, 16, base, "R6 prefetch order");
    cyc(30);
    rd_chk(3'd3, 32'h3401_0000, "R8 R9 partial last fill");
    rd_chk(3'd2, 0, "R9 auto stop");
    rd_chk(3'd4, 3, "R9 isr bits");
    pop_expect(48, 52, base, "R6 prefetch drain order");
    cyc(5);
    rd_chk(3'd3, 0, "R6 empty status");
    fifo_pop(v);
    rd_chk(3'd3, 0, "R6 read at empty keeps pointer");

    // R12 interrupt plumbing
    chk(irq == 1'b0, "R12 irq masked", 32'(irq), 0);
    wr(3'd5, 32'hFFFF);
    rd_chk(3'd5, 32'h0F03, "R12 enable mask");
    @(negedge clk); #1 chk(irq == 1'b1, "R12 irq on", 32'(irq), 1);
    wr(3'd4, 2);
    rd_chk(3'd4, 1, "R12 w1c bit1");
    wr(3'd4, 1);
    rd_chk(3'd4, 0, "R12 w1c bit0");
    @(negedge clk); #1 chk(irq == 1'b0, "R12 irq off", 32'(irq), 0);
    wr(3'd5, 0);

    // R5 16-bit prefetch, odd count; R13 stop
    dev_wide = 1'b1;
    wr(3'd0, 32'h0000_4000);
    wr(3'd1, 7);
    base = 2 * dev_idx;
    wr(3'd2, 1);
    cyc(20);
    rd_chk(3'd3, 32'h0600_0001, "R5 even fill");
    pop_expect(0, 6, base, "R5 low byte first");
    cyc(5);
    rd_chk(3'd2, 1, "R5 still running");
    wr(3'd2, 0);
    rd_chk(3'd2, 0, "R13 stopped");
    rd_chk(3'd3, 0, "R13 remain zero");
    rd_chk(3'd4, 0, "R13 no completion irq");

    // R10 8-bit posting
    dev_wide = 1'b0;
    wr(3'd0, 32'h0000_4001);
    wr(3'd1, 3);
    wr(3'd2, 1);
    rd_chk(3'd3, 32'h4001_0003, "R10 posting start status");
    fifo_pop(v);
    chk(v == 8'h00, "R6 read in posting returns 0", 32'(v), 0);
    rd_chk(3'd3, 32'h4001_0003, "R6 read in posting no effect");
    exp_q.push_back(16'h0011); fifo_push(8'h11);
    exp_q.push_back(16'h0022); fifo_push(8'h22);
    exp_q.push_back(16'h0033); fifo_push(8'h33);
    cyc(3);
    rd_chk(3'd4, 3, "R9 posting completion");
    rd_chk(3'd2, 0, "R9 posting auto stop");
    fifo_push(8'h44); // R10 ignored at zero count
    cyc(3);

    // R11 16-bit posting
    dev_wide = 1'b1;
    wr(3'd4, 3);
    wr(3'd1, 2);
    wr(3'd2, 1);
    fifo_push(8'hA1);
    rd_chk(3'd3, 32'h3F00_0002, "R11 held byte pointer");
    exp_q.push_back(16'hB2A1); fifo_push(8'hB2);
    cyc(2);
    rd_chk(3'd3, 32'h4001_0001, "R11 pair issued");
    fifo_push(8'hC3);
    exp_q.push_back(16'hD4C3); fifo_push(8'hD4);
    cyc(3);
    rd_chk(3'd2, 0, "R11 done");
    rd_chk(3'd4, 3, "R11 completion irq");
    cyc(5);
    chk(exp_q.size() == 0, "R10 all device writes seen", 32'(exp_q.size()), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule